// File: doc/BRIEF.md
# Two-Dimensional Parity Block Corrector

This block guards a payload of seven 4-bit words, typically the BCD digits of a seven-digit decimal number, with one parity bit per word (row) and one parity bit per bit position across all words (column). The encode path takes the 28 data bits and returns them with 7 row parity bits and 4 column parity bits. The decode path takes received data and parity, recomputes both parity sets and forms a row syndrome and a column syndrome.

When exactly one row and exactly one column disagree, the bit where they cross is inverted and the repaired data is returned with a corrected flag and the bit index. Any other nonzero syndrome, such as two flipped data bits or a flipped parity bit, raises an uncorrectable flag and leaves the data as received. Each path has a valid/ready handshake on both sides. Results are registered one cycle after the input is accepted. A parameter chooses odd or even parity, and that choice applies to rows and columns alike.

Top module: `parblk_corrector`

## Requirements
- R1: Word k of the payload occupies data bits [4k+3:4k], with word 0 in the lowest bits. Row parity bit k covers word k. Column parity bit j covers bit j of every word.
- R2: With ODD_PARITY=0, each parity bit makes the count of ones in its group (the covered bits plus the parity bit) even. With ODD_PARITY=1, it makes that count odd.
- R3: The encode output becomes valid on the clock edge after an accepted input (valid and ready both high). Input ready equals (not output valid) or output ready. While output valid is high and output ready is low, the encode outputs hold steady.
- R4: On decode, a zero syndrome returns the data unchanged, with the corrected and uncorrectable flags low and the index 0.
- R5: On decode, a single flipped data bit in word w, bit b, is restored. The corrected flag is 1, the uncorrectable flag is 0 and the index is 4*w+b. The two flags are never high together.
- R6: On decode, two flipped data bits give an uncorrectable flag of 1 and a corrected flag of 0, and the data is returned exactly as received. This holds for two bits in the same word, two bits in the same column, and two bits in different rows and columns.
- R7: On decode, an error only in the parity bits (one syndrome vector nonzero) gives an uncorrectable flag of 1, and the data is returned as received.
- R8: The decode output follows the same handshake and stall-hold rules as R3.
- R9: During reset, both output valid signals are low and both input ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Encode input valid |
| enc_in_ready | output | 1 | Encode input ready |
| enc_in_data | input | 28 | Payload to protect |
| enc_out_valid | output | 1 | Encode result valid |
| enc_out_ready | input | 1 | Encode result accepted downstream |
| enc_out_data | output | 28 | Payload copy |
| enc_out_rowpar | output | 7 | One parity bit per word |
| enc_out_colpar | output | 4 | One parity bit per bit column |
| dec_in_valid | input | 1 | Decode input valid |
| dec_in_ready | output | 1 | Decode input ready |
| dec_in_data | input | 28 | Received payload |
| dec_in_rowpar | input | 7 | Received row parity |
| dec_in_colpar | input | 4 | Received column parity |
| dec_out_valid | output | 1 | Decode result valid |
| dec_out_ready | input | 1 | Decode result accepted downstream |
| dec_out_data | output | 28 | Repaired or passed-through payload |
| dec_out_fixed | output | 1 | A single data bit was corrected |
| dec_out_uncorr | output | 1 | Error detected but not correctable |
| dec_out_index | output | 5 | Index of the corrected bit (0 when none) |

## Verification
Faults inside the block show at the ports one cycle after the word is accepted, because each result register is loaded in that cycle. A wrong syndrome or locator shows in three ways: the data bit comes back unrepaired or the wrong bit is flipped, a flag of the wrong class is raised, or the reported index does not match the injected position. A broken handshake register shows in two ways: output valid misses the cycle after acceptance, or data changes while the output is stalled. The vector set covers single errors at both ends of the payload and in the middle, and double errors in the same row, in the same column and in different rows and columns. It also covers a lone parity-bit error and both parity senses.

// File: rtl/parblk_pkg.sv
package parblk_pkg;
   typedef enum logic [1:0] {
      VERD_CLEAN  = 2'd0,
      VERD_FIXED  = 2'd1,
      VERD_UNCORR = 2'd2
   } verdict_t;
endpackage

// File: rtl/parblk_parity_gen.sv
module parblk_parity_gen #(
   parameter int NUM_WORDS  = 7,
   parameter int WORD_W     = 4,
   parameter int ODD_PARITY = 0,
   localparam int TOTAL     = NUM_WORDS * WORD_W
) (
   input  logic [TOTAL-1:0]     data,
   output logic [NUM_WORDS-1:0] row_par,
   output logic [WORD_W-1:0]    col_par
);
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_row
      if (ODD_PARITY != 0) begin : g_odd
         assign row_par[w] = ~^data[w*WORD_W +: WORD_W];
      end else begin : g_even
         assign row_par[w] = ^data[w*WORD_W +: WORD_W];
      end
   end

   for (genvar c = 0; c < WORD_W; c++) begin : g_col
      always_comb begin
         col_par[c] = (ODD_PARITY != 0);
         for (int w = 0; w < NUM_WORDS; w++) begin
            col_par[c] = col_par[c] ^ data[w*WORD_W + c];
         end
      end
   end
endmodule

// File: rtl/parblk_locator.sv
module parblk_locator
   import parblk_pkg::*;
#(
   parameter int NUM_WORDS = 7,
   parameter int WORD_W    = 4,
   localparam int TOTAL    = NUM_WORDS * WORD_W,
   localparam int IDX_W    = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
   input  logic [NUM_WORDS-1:0] row_syn,
   input  logic [WORD_W-1:0]    col_syn,
   output verdict_t             verdict,
   output logic [IDX_W-1:0]     index,
   output logic [TOTAL-1:0]     flip_mask
);
   logic single;
   int   row_pos;
   int   col_pos;

   assign single = ($countones(row_syn) == 1) && ($countones(col_syn) == 1);

   always_comb begin
      row_pos = 0;
      col_pos = 0;
      for (int r = 0; r < NUM_WORDS; r++) if (row_syn[r]) row_pos = r;
      for (int c = 0; c < WORD_W; c++)    if (col_syn[c]) col_pos = c;
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mw
      for (genvar c = 0; c < WORD_W; c++) begin : g_mc
         assign flip_mask[w*WORD_W + c] = single & row_syn[w] & col_syn[c];
      end
   end

   always_comb begin
      if (single) begin
         verdict = VERD_FIXED;
         index   = IDX_W'(row_pos * WORD_W + col_pos);
      end else if ((|row_syn) || (|col_syn)) begin
         verdict = VERD_UNCORR;
         index   = '0;
      end else begin
         verdict = VERD_CLEAN;
         index   = '0;
      end
   end
endmodule

// File: rtl/parblk_stage.sv
module parblk_stage #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_valid && in_ready) begin
         out_valid <= 1'b1;
         out_data  <= in_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/parblk_corrector.sv
module parblk_corrector
   import parblk_pkg::*;
#(
   parameter int NUM_WORDS  = 7,
   parameter int WORD_W     = 4,
   parameter int ODD_PARITY = 0,
   localparam int TOTAL     = NUM_WORDS * WORD_W,
   localparam int IDX_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enc_in_valid,
   output logic                 enc_in_ready,
   input  logic [TOTAL-1:0]     enc_in_data,
   output logic                 enc_out_valid,
   input  logic                 enc_out_ready,
   output logic [TOTAL-1:0]     enc_out_data,
   output logic [NUM_WORDS-1:0] enc_out_rowpar,
   output logic [WORD_W-1:0]    enc_out_colpar,
   input  logic                 dec_in_valid,
   output logic                 dec_in_ready,
   input  logic [TOTAL-1:0]     dec_in_data,
   input  logic [NUM_WORDS-1:0] dec_in_rowpar,
   input  logic [WORD_W-1:0]    dec_in_colpar,
   output logic                 dec_out_valid,
   input  logic                 dec_out_ready,
   output logic [TOTAL-1:0]     dec_out_data,
   output logic                 dec_out_fixed,
   output logic                 dec_out_uncorr,
   output logic [IDX_W-1:0]     dec_out_index
);
   localparam int ENC_W = TOTAL + NUM_WORDS + WORD_W;
   localparam int DEC_W = TOTAL + 2 + IDX_W;

   if (NUM_WORDS < 1 || WORD_W < 1) begin : g_bad_shape
      $error("parblk_corrector: NUM_WORDS and WORD_W must be positive");
   end
   if (ODD_PARITY != 0 && ODD_PARITY != 1) begin : g_bad_sense
      $error("parblk_corrector: ODD_PARITY must be 0 or 1");
   end

   // encode path
   logic [NUM_WORDS-1:0] enc_row;
   logic [WORD_W-1:0]    enc_col;

   parblk_parity_gen #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ODD_PARITY(ODD_PARITY))
      u_enc_gen (.data(enc_in_data), .row_par(enc_row), .col_par(enc_col));

   parblk_stage #(.WIDTH(ENC_W)) u_enc_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(enc_in_valid), .in_ready(enc_in_ready),
      .in_data({enc_in_data, enc_row, enc_col}),
      .out_valid(enc_out_valid), .out_ready(enc_out_ready),
      .out_data({enc_out_data, enc_out_rowpar, enc_out_colpar})
   );

   // decode path
   logic [NUM_WORDS-1:0] dec_row;
   logic [WORD_W-1:0]    dec_col;
   verdict_t             verdict;
   logic [IDX_W-1:0]     fix_index;
   logic [TOTAL-1:0]     fix_mask;
   logic [TOTAL-1:0]     repaired;

   parblk_parity_gen #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ODD_PARITY(ODD_PARITY))
      u_dec_gen (.data(dec_in_data), .row_par(dec_row), .col_par(dec_col));

   parblk_locator #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_locator (
      .row_syn(dec_row ^ dec_in_rowpar),
      .col_syn(dec_col ^ dec_in_colpar),
      .verdict(verdict), .index(fix_index), .flip_mask(fix_mask)
   );

   assign repaired = dec_in_data ^ fix_mask;

   parblk_stage #(.WIDTH(DEC_W)) u_dec_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(dec_in_valid), .in_ready(dec_in_ready),
      .in_data({repaired, verdict == VERD_FIXED, verdict == VERD_UNCORR, fix_index}),
      .out_valid(dec_out_valid), .out_ready(dec_out_ready),
      .out_data({dec_out_data, dec_out_fixed, dec_out_uncorr, dec_out_index})
   );
endmodule

// File: rtl/parblk_corrector_chk.sv
module parblk_corrector_chk #(
   parameter int NUM_WORDS  = 7,
   parameter int WORD_W     = 4,
   parameter int ODD_PARITY = 0,
   localparam int TOTAL     = NUM_WORDS * WORD_W,
   localparam int IDX_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 enc_in_valid,
   input logic                 enc_in_ready,
   input logic [TOTAL-1:0]     enc_in_data,
   input logic                 enc_out_valid,
   input logic                 enc_out_ready,
   input logic [TOTAL-1:0]     enc_out_data,
   input logic [NUM_WORDS-1:0] enc_out_rowpar,
   input logic [WORD_W-1:0]    enc_out_colpar,
   input logic                 dec_in_valid,
   input logic                 dec_in_ready,
   input logic [TOTAL-1:0]     dec_in_data,
   input logic [NUM_WORDS-1:0] dec_in_rowpar,
   input logic [WORD_W-1:0]    dec_in_colpar,
   input logic                 dec_out_valid,
   input logic                 dec_out_ready,
   input logic [TOTAL-1:0]     dec_out_data,
   input logic                 dec_out_fixed,
   input logic                 dec_out_uncorr,
   input logic [IDX_W-1:0]     dec_out_index
);
   // R3
   enc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_in_valid && enc_in_ready |=> enc_out_valid);
   // R3
   enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_data)
         && $stable(enc_out_rowpar) && $stable(enc_out_colpar));
   // R8
   dec_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_in_valid && dec_in_ready |=> dec_out_valid);
   // R8
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data)
         && $stable(dec_out_fixed) && $stable(dec_out_uncorr) && $stable(dec_out_index));
   // R5
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid |-> !(dec_out_fixed && dec_out_uncorr));
   // R5
   index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid && dec_out_fixed |-> dec_out_index < IDX_W'(TOTAL));
   // R4
   index_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid && !dec_out_fixed |-> dec_out_index == '0);
   // R6
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_in_valid && dec_in_ready |=> dec_out_fixed || dec_out_data == $past(dec_in_data));
endmodule

bind parblk_corrector parblk_corrector_chk #(
   .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ODD_PARITY(ODD_PARITY)
) u_chk (.*);

// File: tb/tb_parblk_corrector.sv
module tb_parblk_corrector;
   localparam int NW = 7;
   localparam int WW = 4;
   localparam int TOT = NW * WW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            enc_in_valid = 1'b0, enc_out_ready = 1'b1;
   logic [TOT-1:0]  enc_in_data = '0;
   logic            dec_in_valid = 1'b0, dec_out_ready = 1'b1;
   logic [TOT-1:0]  dec_in_data = '0;
   logic [NW-1:0]   dec_in_rowpar = '0;
   logic [WW-1:0]   dec_in_colpar = '0;

   logic enc_in_ready, enc_out_valid, dec_in_ready, dec_out_valid;
   logic [TOT-1:0] enc_out_data, dec_out_data;
   logic [NW-1:0]  enc_out_rowpar;
   logic [WW-1:0]  enc_out_colpar;
   logic dec_out_fixed, dec_out_uncorr;
   logic [4:0] dec_out_index;

   logic o_enc_in_ready, o_enc_out_valid, o_dec_in_ready, o_dec_out_valid;
   logic [TOT-1:0] o_enc_out_data, o_dec_out_data;
   logic [NW-1:0]  o_enc_out_rowpar;
   logic [WW-1:0]  o_enc_out_colpar;
   logic o_dec_out_fixed, o_dec_out_uncorr;
   logic [4:0] o_dec_out_index;

   parblk_corrector #(.NUM_WORDS(NW), .WORD_W(WW), .ODD_PARITY(0)) dut (
      .clk, .rst_n, .enc_in_valid, .enc_in_ready, .enc_in_data, .enc_out_valid,
      .enc_out_ready, .enc_out_data, .enc_out_rowpar, .enc_out_colpar,
      .dec_in_valid, .dec_in_ready, .dec_in_data, .dec_in_rowpar, .dec_in_colpar,
      .dec_out_valid, .dec_out_ready, .dec_out_data, .dec_out_fixed,
      .dec_out_uncorr, .dec_out_index);

   parblk_corrector #(.NUM_WORDS(NW), .WORD_W(WW), .ODD_PARITY(1)) dut_odd (
      .clk, .rst_n, .enc_in_valid, .enc_in_ready(o_enc_in_ready), .enc_in_data,
      .enc_out_valid(o_enc_out_valid), .enc_out_ready(1'b1),
      .enc_out_data(o_enc_out_data), .enc_out_rowpar(o_enc_out_rowpar),
      .enc_out_colpar(o_enc_out_colpar), .dec_in_valid, .dec_in_ready(o_dec_in_ready),
      .dec_in_data, .dec_in_rowpar, .dec_in_colpar, .dec_out_valid(o_dec_out_valid),
      .dec_out_ready(1'b1), .dec_out_data(o_dec_out_data),
      .dec_out_fixed(o_dec_out_fixed), .dec_out_uncorr(o_dec_out_uncorr),
      .dec_out_index(o_dec_out_index));

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] m_row(input logic [TOT-1:0] d, input bit odd);
      for (int w = 0; w < NW; w++) m_row[w] = (^d[w*WW +: WW]) ^ odd;
   endfunction

   function automatic logic [WW-1:0] m_col(input logic [TOT-1:0] d, input bit odd);
      for (int c = 0; c < WW; c++) begin
         m_col[c] = odd;
         for (int w = 0; w < NW; w++) m_col[c] ^= d[w*WW + c];
      end
   endfunction

   // vector: data[68:41], error mask[40:13], parity flips[12:2] (row [8:2], col [12:9]), class[1:0]
   // class 0 clean, 1 single correctable, 2 uncorrectable
   localparam logic [68:0] VEC [0:7] = '{
      {28'h2279803, 28'h0000000, 11'h000, 2'd0},
      {28'h2279803, 28'h0000001, 11'h000, 2'd1},
      {28'h1234567, 28'h8000000, 11'h000, 2'd1},
      {28'h9081726, 28'h0002000, 11'h000, 2'd1},
      {28'h2279803, 28'h0000204, 11'h000, 2'd2},
      {28'h5555555, 28'h0000030, 11'h000, 2'd2},
      {28'h0000000, 28'h0000088, 11'h000, 2'd2},
      {28'h9999999, 28'h0000000, 11'h004, 2'd2}
   };

   task automatic push_enc(input logic [TOT-1:0] d);
      @(negedge clk);
      enc_in_valid = 1'b1;
      enc_in_data  = d;
      @(negedge clk);
      enc_in_valid = 1'b0;
   endtask

   task automatic push_dec(input logic [TOT-1:0] d, input logic [NW-1:0] r, input logic [WW-1:0] c);
      @(negedge clk);
      dec_in_valid  = 1'b1;
      dec_in_data   = d;
      dec_in_rowpar = r;
      dec_in_colpar = c;
      @(negedge clk);
      dec_in_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 enc_out_valid in reset", 64'(enc_out_valid), 64'd0);
      check("R9 dec_out_valid in reset", 64'(dec_out_valid), 64'd0);
      check("R9 ready in reset", 64'({enc_in_ready, dec_in_ready}), 64'b11);
      rst_n = 1'b1;

      for (int i = 0; i < 8; i++) begin
         logic [TOT-1:0] d, m;
         logic [10:0] pf;
         logic [1:0] cls;
         logic [NW-1:0] er;
         logic [WW-1:0] ec;
         int pos;
         {d, m, pf, cls} = VEC[i];
         er = m_row(d, 1'b0);
         ec = m_col(d, 1'b0);
         // R1 R2 R3 encode
         push_enc(d);
         check("R3 enc_out_valid after accept", 64'(enc_out_valid), 64'd1);
         check("R1 enc data", 64'(enc_out_data), 64'(d));
         check("R1 R2 even row parity", 64'(enc_out_rowpar), 64'(er));
         check("R1 R2 even col parity", 64'(enc_out_colpar), 64'(ec));
         check("R2 odd row parity", 64'(o_enc_out_rowpar), 64'(m_row(d, 1'b1)));
         check("R2 odd col parity", 64'(o_enc_out_colpar), 64'(m_col(d, 1'b1)));
         // decode
         push_dec(d ^ m, er ^ pf[6:0], ec ^ pf[10:7]);
         check("R8 dec_out_valid after accept", 64'(dec_out_valid), 64'd1);
         pos = 0;
         for (int b = 0; b < TOT; b++) if (m[b]) pos = b;
         case (cls)
            2'd0: begin
               check("R4 clean data", 64'(dec_out_data), 64'(d));
               check("R4 clean flags/index",
                     64'({dec_out_fixed, dec_out_uncorr, dec_out_index}), 64'd0);
            end
            2'd1: begin
               check("R5 corrected data", 64'(dec_out_data), 64'(d));
               check("R5 flags", 64'({dec_out_fixed, dec_out_uncorr}), 64'b10);
               check("R5 index", 64'(dec_out_index), 64'(pos));
            end
            default: begin
               check(pf == 0 ? "R6 data as received" : "R7 data as received",
                     64'(dec_out_data), 64'(d ^ m));
               check(pf == 0 ? "R6 flags" : "R7 flags",
                     64'({dec_out_fixed, dec_out_uncorr}), 64'b01);
            end
         endcase
      end

      // R2 odd-sense decode of an odd-encoded clean word; the even instance rejects it
      push_dec(28'h3141592, m_row(28'h3141592, 1'b1), m_col(28'h3141592, 1'b1));
      check("R2 odd decode clean flags", 64'({o_dec_out_fixed, o_dec_out_uncorr}), 64'd0);
      check("R2 even decode sees wrong sense", 64'(dec_out_uncorr), 64'd1);

      // R8 decode stall: hold and back-pressure
      @(negedge clk);
      dec_out_ready = 1'b0;
      push_dec(28'h1111111 ^ 28'h0000100, m_row(28'h1111111, 1'b0), m_col(28'h1111111, 1'b0));
      dec_in_valid  = 1'b1;
      dec_in_data   = 28'h7654321;
      dec_in_rowpar = m_row(28'h7654321, 1'b0);
      dec_in_colpar = m_col(28'h7654321, 1'b0);
      check("R8 ready low while stalled", 64'(dec_in_ready), 64'd0);
      @(negedge clk);
      check("R8 data held while stalled", 64'(dec_out_data), 64'(28'h1111111));
      check("R8 index held while stalled", 64'(dec_out_index), 64'd8);
      dec_out_ready = 1'b1;
      @(negedge clk);
      dec_in_valid = 1'b0;
      check("R8 next item after release", 64'(dec_out_data), 64'(28'h7654321));

      // R3 encode stall
      enc_out_ready = 1'b0;
      push_enc(28'h0000009);
      enc_in_data  = 28'h8888888;
      enc_in_valid = 1'b1;
      @(negedge clk);
      check("R3 enc ready low while stalled", 64'(enc_in_ready), 64'd0);
      check("R3 enc data held", 64'(enc_out_data), 64'(28'h0000009));
      enc_out_ready = 1'b1;
      @(negedge clk);
      enc_in_valid = 1'b0;
      check("R3 enc next item after release", 64'(enc_out_data), 64'(28'h8888888));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule